// File: doc/BRIEF.md
# Shift and Rotate Unit with Early-Revision Defect Mode

This unit performs the one-bit shift and rotate operations of an 8-bit accumulator datapath. Each operation takes an operand and a carry-in, and it returns the shifted result, the negative, zero and carry flags, and a strobe. The strobe tells the status logic whether the carry should be written back. The operation code is decoded into three datapath controls: the shift direction, the source of the bit shifted in, and carry writeback. The shifter itself only acts on those three controls.

A revision-select input picks between two behaviours. In the late revision all four operations are correct. In the early revision the rotate-right operation reproduces a silicon defect: the operand is shifted left with a zero shifted in, and the carry is left alone. The defect is made only by forcing the three decoded controls, so the shifter is the same in both modes. The flags always describe the value actually produced. With the default parameters, results are registered and update one clock after a valid strobe.

Top module: `shrot_unit`

## Requirements
- R1: Operation code 0 (ASL) gives {operand[6:0], 0} with carry-out operand[7], in both revisions.
- R2: Operation code 1 (LSR) gives {0, operand[7:1]} with carry-out operand[0] and negative flag always 0, in both revisions.
- R3: Operation code 2 (ROL) gives {operand[6:0], carryIn} with carry-out operand[7], in both revisions.
- R4: Operation code 3 (ROR) with earlyRev=0 gives {carryIn, operand[7:1]} with carry-out operand[0].
- R5: Operation code 3 with earlyRev=1 gives {operand[6:0], 0} regardless of carryIn (0x01 to 0x02, 0x05 to 0x0A, 0xFF to 0xFE).
- R6: Operation code 3 with earlyRev=1 returns carry-out equal to carryIn and deasserts carryWeOut.
- R7: negOut equals bit 7 of the produced result and zeroOut is 1 exactly when the produced result is 0x00, including defective results (early ROR gives Z=1 for 0x00 and 0x80, and N=1 for 0x40 to 0x7F and 0xC0 to 0xFF).
- R8: For operation codes 0, 1 and 2 every output is identical for earlyRev=0 and earlyRev=1.
- R9: All outputs update on the clock edge where validIn is 1, hold their value while validIn is 0, and are 0 after reset. validOut is validIn delayed one clock.
- R10: carryWeOut is 1 for every operation except operation code 3 with earlyRev=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| validIn | input | 1 | Captures a new operation |
| opIn | input | 2 | 0 ASL, 1 LSR, 2 ROL, 3 ROR |
| earlyRev | input | 1 | 1 selects the early defective rotate-right |
| operandIn | input | 8 | Operand |
| carryIn | input | 1 | Current carry flag |
| resultOut | output | 8 | Shifted or rotated value |
| negOut | output | 1 | Negative flag of the result |
| zeroOut | output | 1 | Zero flag of the result |
| carryOut | output | 1 | New carry value |
| carryWeOut | output | 1 | Carry writeback enable |
| validOut | output | 1 | Outputs hold a fresh result |

## Verification
A wrong direction control shows up as a mirrored result one clock after the strobe. A wrong fill source shows as a wrong bit 0 or bit 7 only when carryIn is 1. A wrong writeback control shows as an unexpected carryWeOut level, or as a carry-out that tracks the operand instead of carryIn. The sweep of every operand and carry pairing for every operation in both revisions catches each of these on the first vector that exercises the control. The flag checks are made on the same cycle as the result.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  typedef enum logic [1:0] {
    OP_ASL = 2'd0,
    OP_LSR = 2'd1,
    OP_ROL = 2'd2,
    OP_ROR = 2'd3
  } shOp_e;

  // strobes from decode to datapath
  typedef struct packed {
    logic shiftLeft;
    logic fillFromCarry;
    logic carryWrite;
  } shCtrl_t;
endpackage

// File: rtl/shrot_ctrl.sv
module shrot_ctrl
  import shrot_pkg::*;
(
  input  logic [1:0] opIn,
  input  logic       earlyRev,
  output shCtrl_t    ctrlOut
);
  shOp_e   op;
  shCtrl_t base;

  assign op = shOp_e'(opIn);

  always_comb begin
    base.carryWrite = 1'b1;
    unique case (op)
      OP_ASL: begin base.shiftLeft = 1'b1; base.fillFromCarry = 1'b0; end
      OP_LSR: begin base.shiftLeft = 1'b0; base.fillFromCarry = 1'b0; end
      OP_ROL: begin base.shiftLeft = 1'b1; base.fillFromCarry = 1'b1; end
      default: begin base.shiftLeft = 1'b0; base.fillFromCarry = 1'b1; end
    endcase
  end

  // the early defect corrupts all three controls of rotate-right only
  always_comb begin
    ctrlOut = base;
    if (earlyRev && op == OP_ROR) begin
      ctrlOut.shiftLeft     = 1'b1;
      ctrlOut.fillFromCarry = 1'b0;
      ctrlOut.carryWrite    = 1'b0;
    end
  end
endmodule

// File: rtl/shrot_dpath.sv
module shrot_dpath
  import shrot_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] operand,
  input  logic             carryIn,
  input  shCtrl_t          ctrl,
  output logic [WIDTH-1:0] result,
  output logic             negFlag,
  output logic             zeroFlag,
  output logic             carryNew,
  output logic             carryWe
);
  localparam int MSB = WIDTH - 1;

  logic fillBit;
  logic lostBit;

  assign fillBit  = ctrl.fillFromCarry ? carryIn : 1'b0;
  assign result   = ctrl.shiftLeft ? {operand[MSB-1:0], fillBit}
                                   : {fillBit, operand[MSB:1]};
  assign lostBit  = ctrl.shiftLeft ? operand[MSB] : operand[0];
  assign carryNew = ctrl.carryWrite ? lostBit : carryIn;
  assign carryWe  = ctrl.carryWrite;
  assign negFlag  = result[MSB];
  assign zeroFlag = (result == '0);
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             validIn,
  input  logic [1:0]       opIn,
  input  logic             earlyRev,
  input  logic [WIDTH-1:0] operandIn,
  input  logic             carryIn,
  output logic [WIDTH-1:0] resultOut,
  output logic             negOut,
  output logic             zeroOut,
  output logic             carryOut,
  output logic             carryWeOut,
  output logic             validOut
);
  localparam int MSB = WIDTH - 1;

  shCtrl_t          ctrl;
  logic [WIDTH-1:0] resC;
  logic             negC, zeroC, carryC, weC;

  shrot_ctrl u_ctrl (
    .opIn    (opIn),
    .earlyRev(earlyRev),
    .ctrlOut (ctrl)
  );

  shrot_dpath #(.WIDTH(WIDTH)) u_dpath (
    .operand (operandIn),
    .carryIn (carryIn),
    .ctrl    (ctrl),
    .result  (resC),
    .negFlag (negC),
    .zeroFlag(zeroC),
    .carryNew(carryC),
    .carryWe (weC)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rstN) begin
          resultOut  <= '0;
          negOut     <= 1'b0;
          zeroOut    <= 1'b0;
          carryOut   <= 1'b0;
          carryWeOut <= 1'b0;
          validOut   <= 1'b0;
        end else begin
          validOut <= validIn;
          if (validIn) begin
            resultOut  <= resC;
            negOut     <= negC;
            zeroOut    <= zeroC;
            carryOut   <= carryC;
            carryWeOut <= weC;
          end
        end
      end

      AST_EARLY_ROR_NO_WE: assert property (@(posedge clk) disable iff (!rstN)
        (validIn && earlyRev && opIn == 2'd3) |=> !carryWeOut) else $error("no we"); // R6
      AST_EARLY_ROR_KEEP_C: assert property (@(posedge clk) disable iff (!rstN)
        (validIn && earlyRev && opIn == 2'd3) |=> (carryOut == $past(carryIn))) else $error("keep c"); // R6
      AST_LSR_NOT_NEG: assert property (@(posedge clk) disable iff (!rstN)
        (validIn && opIn == 2'd1) |=> !negOut) else $error("lsr neg"); // R2
      AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
        !validIn |=> ($stable(resultOut) && $stable(carryOut) && $stable(carryWeOut))) else $error("hold"); // R9
      AST_LATE_WE: assert property (@(posedge clk) disable iff (!rstN)
        (validIn && !(earlyRev && opIn == 2'd3)) |=> carryWeOut) else $error("we"); // R10
      AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rstN)
        validOut |-> (zeroOut == (resultOut == '0) && negOut == resultOut[MSB])) else $error("flags"); // R7
    end else begin : g_comb
      assign resultOut  = resC;
      assign negOut     = negC;
      assign zeroOut    = zeroC;
      assign carryOut   = carryC;
      assign carryWeOut = weC;
      assign validOut   = validIn;
    end
  endgenerate
endmodule

// File: tb/sim_shrot_unit.sv
module sim_shrot_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic       validIn;
  logic [1:0] opIn;
  logic       earlyRev;
  logic [7:0] operandIn;
  logic       carryIn;
  logic [7:0] resultOut;
  logic       negOut, zeroOut, carryOut, carryWeOut, validOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shrot_unit u0 (
    .clk(clk), .rstN(rstN), .validIn(validIn), .opIn(opIn),
    .earlyRev(earlyRev), .operandIn(operandIn), .carryIn(carryIn),
    .resultOut(resultOut), .negOut(negOut), .zeroOut(zeroOut),
    .carryOut(carryOut), .carryWeOut(carryWeOut), .validOut(validOut)
  );

  task automatic chk(input string tag, input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h (op=%0d early=%0d a=%h c=%0d)",
               tag, act, exp, opIn, earlyRev, operandIn, carryIn);
    end
  endtask

  // {result, n, z, c, we, valid}
  task automatic runVec(input int rev, input int op, input int a, input int c);
    int res, co, we;
    string tag;
    @(negedge clk);
    validIn = 1'b1; earlyRev = rev[0]; opIn = op[1:0];
    operandIn = a[7:0]; carryIn = c[0];
    we = 1;
    case (op)
      0: begin res = (a * 2) % 256;       co = a / 128; tag = (rev != 0) ? "R1 R8" : "R1"; end
      1: begin res = a / 2;               co = a % 2;   tag = (rev != 0) ? "R2 R8" : "R2"; end
      2: begin res = (a * 2) % 256 + c;   co = a / 128; tag = (rev != 0) ? "R3 R8" : "R3"; end
      default: begin
        if (rev != 0) begin res = (a * 2) % 256; co = c; we = 0; tag = "R5 R6 R10"; end
        else begin res = c * 128 + a / 2; co = a % 2; tag = "R4 R10"; end
      end
    endcase
    @(negedge clk);
    chk(tag, {resultOut, carryOut, carryWeOut, validOut, 2'b00},
             {res[7:0], co[0], we[0], 1'b1, 2'b00});
    chk("R7", {11'd0, negOut, zeroOut}, {11'd0, (res >= 128), (res == 0)});
  endtask

  initial begin
    rstN = 1'b0; validIn = 1'b0; opIn = 2'd0; earlyRev = 1'b0;
    operandIn = 8'h00; carryIn = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 reset", {resultOut, negOut, zeroOut, carryOut, carryWeOut, validOut},
                    13'd0);
    rstN = 1'b1;
    for (int rev = 0; rev < 2; rev++)
      for (int op = 0; op < 4; op++)
        for (int a = 0; a < 256; a++)
          for (int c = 0; c < 2; c++)
            runVec(rev, op, a, c);
    // R5 named examples in early mode with carry set
    runVec(1, 3, 8'h01, 1); chk("R5 01", {5'd0, resultOut}, {5'd0, 8'h02});
    runVec(1, 3, 8'h05, 1); chk("R5 05", {5'd0, resultOut}, {5'd0, 8'h0A});
    runVec(1, 3, 8'h80, 0); chk("R7 80", {12'd0, zeroOut}, 13'd1);
    // R9 hold while idle: last was early ROR of 0x80 -> 0x00, we=0
    @(negedge clk);
    validIn = 1'b0; opIn = 2'd1; earlyRev = 1'b0; operandIn = 8'hFF; carryIn = 1'b1;
    @(negedge clk);
    chk("R9 hold", {resultOut, carryWeOut, validOut, 3'b000}, {8'h00, 1'b0, 1'b0, 3'b000});
    @(negedge clk);
    chk("R9 hold2", {resultOut, carryOut, carryWeOut, 3'b000}, {8'h00, 1'b0, 1'b0, 3'b000});
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog act=timeout exp=finish");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule